// File: doc/BRIEF.md
# Four-Lane Multi-Format Audio Serializer

This block turns eight channels of parallel PCM audio into four serial data lanes that share one bit clock (`sclk`) and one word clock (`lrclk`). Each lane carries a stereo pair. The left channel goes out in the first half of a frame and the right channel in the second half. Each half spans 32 bit-clock slots. A 2-bit mode picks one of four line formats. Three of them are justification variants of a plain serial word: I2S, left-justified and right-justified. The fourth is a biphase-mark coded AES3-style subframe stream on every lane. A 5-bit field sets how many sample bits are sent.

The block runs from a system clock. One bit-clock slot lasts two system clock cycles: `sclk` is low in the first cycle and high in the second. Each frame is 64 slots, which is 128 system cycles. A new set of eight samples is offered on `smp_data` with `smp_valid`. The block takes it in the last cycle of every frame, while `smp_ready` is high. The mode and width inputs are sampled at that same edge, so a frame is always sent with one consistent set of settings.

Top module: `aud_serial_tx`

## Requirements
- R1: While `rst_n` is low and right after reset: `sclk`, `lrclk`, `smp_ready` and all lanes are 0. The active mode is I2S, the active width is 24, and the held samples are zero.
- R2: `sclk` toggles on every system clock, so each slot is one low cycle followed by one high cycle. A frame is 64 slots. `lrclk` changes only at the start of slot 0 of a half. In mode 0 `lrclk` is low for the left half. In modes 1, 2 and 3 it is high for the left half.
- R3: Lane L (0 to 3) carries channel 2L+1 in the left half and channel 2L+2 in the right half. Channel c (1 to 8) is read from `smp_data[24*(c-1) +: 24]`.
- R4: Mode 0 (I2S): the sample goes out MSB first, with the MSB in slot 1 of the half. Slots that hold no sample bit are 0.
- R5: Mode 2 (left-justified): the sample goes out MSB first, with the MSB in slot 0. Slots that hold no sample bit are 0.
- R6: Mode 1 (right-justified): the sample goes out MSB first, with the LSB in slot 31. Slots that hold no sample bit are 0.
- R7: A `word_width` value w in 1..24 sends the w most significant bits of each 24-bit sample and treats the lower bits as zero. A value of 0 or above 24 acts as 24.
- R8: Mode 3 (AES3): each half is a 32-slot subframe and each slot is two half-cells, one per system cycle. Slots 0-3 carry an 8-half-cell preamble. The patterns are B=11101000, M=11100010 and W=11100100, sent left to right from a line level of 0. Slots 4-27 carry the width-masked sample LSB first. Slots 28-30 (validity, user, channel status) are 0. Slot 31 is even parity over slots 4-30. Data slots are biphase-mark coded: the level inverts at the start of every slot and again mid-slot for a 1.
- R9: In mode 3, the left subframe uses preamble B when the frame index since reset modulo 192 is 0, and M otherwise. The right subframe always uses W.
- R10: `smp_ready` is high only in the last system cycle of each frame. If `smp_valid` is high there, the eight samples are taken for the next frame. If not, the next frame sends all-zero samples.
- R11: `fmt_mode` and `word_width` are sampled only at that same frame-end edge. Changing them during a frame does not alter the frame being sent.
- R12: In modes 0-2, a lane changes only at the start of a slot (the falling `sclk` edge) and is stable while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two cycles per bit slot |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | A sample set is offered |
| smp_ready | output | 1 | Last cycle of a frame; sample set taken here |
| smp_data | input | 192 | Eight 24-bit channels, channel 1 in the low bits |
| fmt_mode | input | 2 | 0 I2S, 1 right-justified, 2 left-justified, 3 AES3 |
| word_width | input | 5 | Sample bits sent, 1..24 |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right word clock |
| sdata | output | 4 | Serial data lanes |

## Verification
The serializer is driven with a different sample pattern on each channel in every frame, so a swapped channel, a swapped lane or a stale sample shows up at once. It cycles through each of the three justified modes at full width and at short widths (12, 16, 20). Those frames separate the MSB start slot of each mode, and a width of 0 and of 31 confirm the clamp to 24. A frame without `smp_valid` must come out silent. Mode and width inputs are changed during every frame, which would expose any settings that take effect early. Just over 192 AES3 frames run with mixed widths, which checks the biphase levels, the parity and the return of preamble B at the start of each block.

// File: rtl/aud_serial_tx.sv
`timescale 1ns/1ps
module aud_serial_tx #(
  parameter int LANES = 4,
  parameter int SW    = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [2*LANES*SW-1:0]   smp_data,
  input  logic [1:0]              fmt_mode,
  input  logic [4:0]              word_width,
  output logic                    sclk,
  output logic                    lrclk,
  output logic [LANES-1:0]        sdata
);
  localparam int CH     = 2 * LANES;
  localparam int SLOTS  = 32;
  localparam int FRAMES = 192;
  localparam logic [7:0] PRE_B = 8'b11101000;
  localparam logic [7:0] PRE_M = 8'b11100010;
  localparam logic [7:0] PRE_W = 8'b11100100;

  logic [6:0]       cnt;
  logic [7:0]       blk;
  logic [1:0]       mode_q;
  logic [4:0]       wid_q;
  logic [SW-1:0]    smp_q [CH];
  logic [LANES-1:0] endlvl;
  logic [LANES-1:0] just_bit, aes_bit;
  logic [SW-1:0]    word [LANES];
  logic [7:0]       pre;
  logic             dbit;
  int               k;

  logic       phase, half;
  logic [4:0] slot, wid_in;
  logic [SW-1:0] wmask;

  assign phase     = cnt[0];
  assign slot      = cnt[5:1];
  assign half      = cnt[6];
  assign wid_in    = (word_width == 5'd0 || word_width > 5'(SW)) ? 5'(SW) : word_width;
  assign wmask     = {SW{1'b1}} << (5'(SW) - wid_q);
  assign smp_ready = (cnt == 7'd127);
  assign sclk      = phase;
  assign lrclk     = (mode_q == 2'd0) ? half : ~half;
  assign pre       = half ? PRE_W : ((blk == 8'd0) ? PRE_B : PRE_M);
  assign sdata     = (mode_q == 2'd3) ? aes_bit : just_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      blk    <= '0;
      mode_q <= 2'd0;
      wid_q  <= 5'(SW);
      endlvl <= '0;
      for (int c = 0; c < CH; c++) smp_q[c] <= '0;
    end else begin
      cnt <= cnt + 7'd1;
      if (phase) endlvl <= aes_bit;
      if (smp_ready) begin
        mode_q <= fmt_mode;
        wid_q  <= wid_in;
        blk    <= (blk == 8'(FRAMES-1)) ? 8'd0 : blk + 8'd1;
        for (int c = 0; c < CH; c++)
          smp_q[c] <= smp_valid ? smp_data[c*SW +: SW] : '0;
      end
    end
  end

  always_comb begin
    k    = 0;
    dbit = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      word[l] = (half ? smp_q[2*l+1] : smp_q[2*l]) & wmask;

      case (mode_q)
        2'd0:    k = int'(slot) - 1;
        2'd2:    k = int'(slot);
        default: k = int'(slot) - (SLOTS - int'(wid_q));
      endcase
      just_bit[l] = (k >= 0 && k < int'(wid_q)) ? word[l][SW-1-k] : 1'b0;

      if (slot <= 5'd27)      dbit = word[l][slot - 5'd4];
      else if (slot == 5'd31) dbit = ^word[l];
      else                    dbit = 1'b0;

      if (slot < 5'd4)  aes_bit[l] = pre[~{slot[1:0], phase}];
      else if (!phase)  aes_bit[l] = ~endlvl[l];
      else              aes_bit[l] = dbit ? endlvl[l] : ~endlvl[l];
    end
  end
endmodule

// File: rtl/aud_serial_tx_chk.sv
`timescale 1ns/1ps
module aud_serial_tx_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             lrclk,
  input logic             smp_ready,
  input logic [LANES-1:0] sdata,
  input logic [1:0]       mode_q,
  input logic [4:0]       slot
);
  // R2
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !sclk |=> sclk);
  // R2
  sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) sclk |=> !sclk);
  // R2
  lrclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lrclk != $past(lrclk)) |-> (!sclk && slot == 5'd0));
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_ready |=> !smp_ready);
  // R12
  just_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'd3 && sclk) |-> $stable(sdata));
  // R8
  aes_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && !sclk && slot >= 5'd4) |-> (sdata == ~$past(sdata)));
endmodule

bind aud_serial_tx aud_serial_tx_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrclk(lrclk), .smp_ready(smp_ready),
  .sdata(sdata), .mode_q(mode_q), .slot(slot)
);

// File: tb/test_aud_serial_tx.sv
`timescale 1ns/1ps
module test_aud_serial_tx;
  localparam int LANES = 4;
  localparam int SW    = 24;
  localparam int CH    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [CH*SW-1:0] smp_data = '0;
  logic [1:0] fmt_mode = 2'd0;
  logic [4:0] word_width = 5'd24;
  logic smp_ready, sclk, lrclk;
  logic [LANES-1:0] sdata;

  int n_chk = 0;
  int n_fail = 0;
  int nfr = 0;

  aud_serial_tx i_aud_serial_tx (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .fmt_mode(fmt_mode), .word_width(word_width),
    .sclk(sclk), .lrclk(lrclk), .sdata(sdata)
  );

  always #2.5 clk = ~clk;

  // reference model state
  int m_cnt = 0, m_blk = 0, m_mode = 0, m_wid = 24, m_frame = 0;
  bit m_silent = 0, live = 0;
  logic [SW-1:0] m_smp [CH];

  function automatic int eff_w(input int w);
    return (w == 0 || w > 24) ? 24 : w;
  endfunction

  function automatic logic [SW-1:0] msk(input logic [SW-1:0] v, input int w);
    logic [SW-1:0] r = '0;
    for (int b = 0; b < w; b++) r[SW-1-b] = v[SW-1-b];
    return r;
  endfunction

  function automatic logic aes_hc(input logic [SW-1:0] w, input logic [7:0] pat, input int idx);
    logic lvl = 1'b0;
    logic b;
    int ones = 0;
    if (idx < 8) return pat[7-idx];
    for (int s = 4; s < 32; s++) begin
      if (s <= 27) b = w[s-4];
      else if (s == 31) b = ones[0];
      else b = 1'b0;
      if (s <= 30 && b) ones++;
      lvl = ~lvl;
      if (2*s == idx) return lvl;
      if (b) lvl = ~lvl;
      if (2*s+1 == idx) return lvl;
    end
    return 1'b0;
  endfunction

  function automatic logic [SW-1:0] pattern(input int n, input int c);
    int v = n * 32'h009E3779 + (c + 1) * 32'h0005A5A5 + (c << 20);
    return v[SW-1:0] ^ {SW{n[0]}};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_blk = 0; m_mode = 0; m_wid = 24; m_frame = 0; m_silent = 0;
      for (int c = 0; c < CH; c++) m_smp[c] = '0;
    end else begin
      if (m_cnt == 127) begin
        m_mode = fmt_mode;
        m_wid = eff_w(word_width);
        m_silent = !smp_valid;
        for (int c = 0; c < CH; c++) m_smp[c] = smp_valid ? smp_data[c*SW +: SW] : '0;
        m_blk = (m_blk + 1) % 192;
        m_frame++;
      end
      m_cnt = (m_cnt + 1) % 128;
      live = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      int ph, sl, hf, first, pos;
      logic [SW-1:0] w;
      logic [7:0] pat;
      logic e;
      string tag;
      ph = m_cnt % 2; sl = (m_cnt / 2) % 32; hf = m_cnt / 64;
      chk("R2 sclk", sclk, ph);
      chk("R2 lrclk", lrclk, (m_mode == 0) ? hf : 1 - hf);
      chk("R10 smp_ready", smp_ready, m_cnt == 127);
      case (m_mode)
        0: begin tag = "R3 R4"; first = 1; end
        1: begin tag = "R3 R6"; first = 32 - m_wid; end
        2: begin tag = "R3 R5"; first = 0; end
        default: begin tag = "R3 R8"; first = 0; end
      endcase
      if (m_wid != 24) tag = {tag, " R7"};
      if (m_silent) tag = {tag, " R10"};
      if (m_frame == 0) tag = {tag, " R1"};
      if (fmt_mode != m_mode || eff_w(word_width) != m_wid) tag = {tag, " R11"};
      pat = hf ? 8'b11100100 : ((m_blk == 0) ? 8'b11101000 : 8'b11100010);
      if (m_mode == 3 && sl < 4) tag = {tag, " R9"};
      for (int l = 0; l < LANES; l++) begin
        w = msk(m_smp[2*l + hf], m_wid);
        if (m_mode == 3) e = aes_hc(w, pat, 2*sl + ph);
        else begin
          pos = sl - first;
          e = (pos >= 0 && pos < m_wid) ? w[SW-1-pos] : 1'b0;
        end
        chk($sformatf("%s lane%0d slot%0d", tag, l, sl), sdata[l], e);
      end
    end
  end

  task automatic frame(input int m, input int wd, input bit v);
    fmt_mode = 2'(m);
    word_width = 5'(wd);
    smp_valid = v;
    for (int c = 0; c < CH; c++) smp_data[c*SW +: SW] = pattern(nfr, c);
    nfr++;
    do @(negedge clk); while (!smp_ready);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      // R1 reset values
      chk("R1 sclk", sclk, 0);
      chk("R1 lrclk", lrclk, 0);
      chk("R1 smp_ready", smp_ready, 0);
      chk("R1 sdata", sdata, 0);
    end
    rst_n = 1'b1;
    frame(0, 24, 1);
    frame(0, 24, 1);
    frame(2, 24, 1);
    frame(1, 24, 1);
    frame(1, 16, 1);
    frame(2, 12, 1);
    frame(0, 20, 1);
    frame(0, 0, 1);   // R7 clamp of 0
    frame(1, 31, 1);  // R7 clamp above 24
    frame(2, 24, 0);  // R10 no valid gives silence
    frame(0, 24, 1);
    for (int i = 0; i < 196; i++) begin
      // R8 R9 AES3 across a block boundary
      frame(3, (i % 3 == 0) ? 16 : 24, (i != 50));
    end
    frame(0, 24, 1);
    frame(2, 8, 1);
    repeat (130) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule